// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between the framebuffer fetch path and the palette/colour stage of a display controller. It accepts 32-bit words on a valid/ready stream and turns each word into a run of pixels, one per output beat. A 3-bit depth code selects the pixel size. Two ordering controls decide where each pixel sits in the word, and a colour-order control swaps the red and blue outputs. Indexed depths produce an 8-bit palette index with an indexed flag. The direct-colour depths produce 8-bit red, green and blue values.

The `EXTENDED` parameter picks the controller variant. The extended variant decodes all eight depth codes natively. The base variant has a 16-bit mode whose layout comes from an external 2-bit mux code, and it treats codes 6 and 7 as code 4. The depth code and the ordering and colour controls are captured with each input word, so they may change between words. Apart from the stream, the block also computes the number of bytes in one line of the framebuffer from a pixel width and the current depth code.

Top module: `fb_unpacker`

## Requirements
- R1: While reset is held, and after it until the first word arrives, `out_valid` is 0 and `in_ready` is 1.
- R2: A word accepted at one clock edge is presented from the next cycle. Its pixels come out in index order. A stalled pixel (`out_valid` high, `out_ready` low) holds its value and keeps `in_ready` low. The word is released only when its last pixel is accepted, and a new word may be taken at that same edge.
- R3: Depth codes 0, 1, 2 and 3 give 32, 16, 8 and 4 indexed pixels per word of 1, 2, 4 and 8 bits. With both ordering controls clear, pixel k is word bits [k*s +: s], so the least significant pixel comes first. Indexed outputs set `out_indexed` to 1, put the zero-extended index in `out_index`, and drive zero on red, green and blue.
- R4: With `cfg_be_pix`=1 and `cfg_be_byte`=0, bytes are taken least significant first. Within each byte, sub-byte pixels are taken most significant first, so pixel k sits at bits [8*(k/(8/s)) + 8 - ((k mod (8/s))+1)*s +: s]. Pixels of 8 bits or more keep the order of R3.
- R5: With `cfg_be_byte`=1, whatever the value of `cfg_be_pix`, the word is read from its top: pixel k is bits [32-(k+1)*s +: s].
- R6: The 5551 layout takes red from bits [4:0], green from [9:5] and blue from [14:10], each shifted left by 3. Bit 15 is ignored. Pixels are 16-bit slots, two per word.
- R7: The 565 layout takes red from [4:0] shifted left by 3, green from [10:5] shifted left by 2, and blue from [15:11] shifted left by 3.
- R8: Depth code 5 gives one pixel per word, with red [7:0], green [15:8] and blue [23:16], and bits [31:24] ignored. On the extended variant, code 7 gives two 16-bit slots per word with red [3:0], green [7:4] and blue [11:8], each shifted left by 4.
- R9: With `cfg_bgr`=1, a direct-colour pixel has its red and blue outputs exchanged. Indexed pixels are unaffected.
- R10: On the base variant, codes 4, 6 and 7 behave as a 16-bit mode selected by `fmt_mux`. A value of 1 gives 5551 and honours `cfg_bgr`. A value of 3 gives 565 with red and blue always exchanged. Values 0 and 2 give 565 and honour `cfg_bgr`.
- R11: On the extended variant, code 4 is always 5551 and code 6 is always 565, whatever the value of `fmt_mux`.
- R12: `line_bytes` equals `line_width`>>3, >>2 or >>1 for codes 0, 1 and 2. It equals `line_width` for code 3, `line_width`<<2 for code 5, and `line_width`<<1 for codes 4, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 3 | Depth code, captured with each word |
| cfg_bgr | input | 1 | Exchange red and blue on direct colour |
| cfg_be_byte | input | 1 | Big-endian word ordering, takes priority |
| cfg_be_pix | input | 1 | Big-endian sub-byte pixel ordering |
| fmt_mux | input | 2 | 16-bit layout select for the base variant |
| line_width | input | LINE_W | Line width in pixels |
| line_bytes | output | LINE_W+2 | Bytes per framebuffer line |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_word | input | DATA_W | Framebuffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_indexed | output | 1 | Pixel is a palette index |
| out_index | output | 8 | Palette index |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |

## Verification
The assertions assume a downstream that obeys the stream rules. They also assume that `cfg_depth` and `line_width` are stable inputs when `line_bytes` is sampled. They need nothing from the configuration while a word is in flight, because the format is captured at acceptance. The stimulus changes the configuration only while the block is idle. It offers a competing word only during a deliberate stall, to show that the word is refused. It sweeps every depth code, ordering combination, colour order and mux value on both variants side by side.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
   typedef enum logic [2:0] {
      FMT_IDX  = 3'd0,
      FMT_5551 = 3'd1,
      FMT_565  = 3'd2,
      FMT_444  = 3'd3,
      FMT_888  = 3'd4
   } fmt_kind_e;

   typedef enum logic [1:0] {
      ORD_LE      = 2'd0,
      ORD_BE_PIX  = 2'd1,
      ORD_BE_BYTE = 2'd2
   } order_e;

   // lsz: log2 of the pixel slot size in bits
   typedef struct packed {
      fmt_kind_e  kind;
      logic [2:0] lsz;
      logic       swap;
   } pix_fmt_t;

   typedef struct packed {
      logic       indexed;
      logic [7:0] index;
      logic [7:0] red;
      logic [7:0] green;
      logic [7:0] blue;
   } pix_out_t;

   localparam pix_fmt_t FMT_RESET = '{kind: FMT_IDX, lsz: 3'd0, swap: 1'b0};
endpackage

// File: rtl/fbu_format.sv
module fbu_format
   import fbu_pkg::*;
#(
   parameter int unsigned EXTENDED = 1
) (
   input  logic [2:0] depth,
   input  logic       bgr,
   input  logic [1:0] mux,
   output pix_fmt_t   fmt
);
   if (EXTENDED != 0) begin : g_ext
      always_comb begin
         fmt = '{kind: FMT_IDX, lsz: depth, swap: bgr};
         case (depth)
            3'd4:    fmt = '{kind: FMT_5551, lsz: 3'd4, swap: bgr};
            3'd5:    fmt = '{kind: FMT_888,  lsz: 3'd5, swap: bgr};
            3'd6:    fmt = '{kind: FMT_565,  lsz: 3'd4, swap: bgr};
            3'd7:    fmt = '{kind: FMT_444,  lsz: 3'd4, swap: bgr};
            default: fmt = '{kind: FMT_IDX,  lsz: depth, swap: 1'b0};
         endcase
      end
      logic unused_mux;
      assign unused_mux = ^mux;
   end else begin : g_base
      pix_fmt_t fmt16;
      always_comb begin
         case (mux)
            2'd1:    fmt16 = '{kind: FMT_5551, lsz: 3'd4, swap: bgr};
            2'd3:    fmt16 = '{kind: FMT_565,  lsz: 3'd4, swap: 1'b1};
            default: fmt16 = '{kind: FMT_565,  lsz: 3'd4, swap: bgr};
         endcase
      end
      always_comb begin
         case (depth)
            3'd4, 3'd6, 3'd7: fmt = fmt16;
            3'd5:             fmt = '{kind: FMT_888, lsz: 3'd5, swap: bgr};
            default:          fmt = '{kind: FMT_IDX, lsz: depth, swap: 1'b0};
         endcase
      end
   end
endmodule

// File: rtl/fbu_select.sv
module fbu_select
   import fbu_pkg::*;
#(
   parameter  int unsigned DATA_W = 32,
   localparam int unsigned CNT_W  = $clog2(DATA_W),
   localparam int unsigned SH_W   = CNT_W + 3
) (
   input  logic [DATA_W-1:0] word,
   input  order_e            order,
   input  logic [2:0]        lsz,
   input  logic [CNT_W-1:0]  slot,
   output logic [DATA_W-1:0] field
);
   logic [SH_W-1:0] slot_w, pos_le, pos_top, pos_bep, sh;
   logic [SH_W-1:0] per_byte, byte_i, sub_i;
   logic [2:0]      sub_sh;
   logic [DATA_W:0] mask_wide;
   logic            unused_mask_msb;

   assign slot_w   = SH_W'(slot);
   assign pos_le   = slot_w << lsz;
   assign pos_top  = SH_W'(DATA_W) - ((slot_w + SH_W'(1)) << lsz);
   assign sub_sh   = 3'd3 - lsz;
   assign per_byte = SH_W'(8) >> lsz;
   assign byte_i   = slot_w >> sub_sh;
   assign sub_i    = slot_w & (per_byte - SH_W'(1));
   assign pos_bep  = (byte_i << 3) + SH_W'(8) - ((sub_i + SH_W'(1)) << lsz);

   always_comb begin
      case (order)
         ORD_BE_BYTE: sh = pos_top;
         ORD_BE_PIX:  sh = (lsz < 3'd3) ? pos_bep : pos_le;
         default:     sh = pos_le;
      endcase
   end

   assign mask_wide       = ((DATA_W+1)'(1) << (SH_W'(1) << lsz)) - (DATA_W+1)'(1);
   assign unused_mask_msb = mask_wide[DATA_W];
   assign field           = (word >> sh) & mask_wide[DATA_W-1:0];
endmodule

// File: rtl/fbu_color.sv
module fbu_color
   import fbu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  pix_fmt_t          fmt,
   input  logic [DATA_W-1:0] field,
   output pix_out_t          px
);
   logic [7:0] r, g, b;
   logic       unused_hi;

   assign unused_hi = ^field[DATA_W-1:24];

   always_comb begin
      r = '0; g = '0; b = '0;
      case (fmt.kind)
         FMT_5551: begin
            r = {field[4:0],   3'b000};
            g = {field[9:5],   3'b000};
            b = {field[14:10], 3'b000};
         end
         FMT_565: begin
            r = {field[4:0],   3'b000};
            g = {field[10:5],  2'b00};
            b = {field[15:11], 3'b000};
         end
         FMT_444: begin
            r = {field[3:0],  4'b0000};
            g = {field[7:4],  4'b0000};
            b = {field[11:8], 4'b0000};
         end
         FMT_888: begin
            r = field[7:0];
            g = field[15:8];
            b = field[23:16];
         end
         default: ;
      endcase
   end

   always_comb begin
      px.indexed = (fmt.kind == FMT_IDX);
      px.index   = px.indexed ? field[7:0] : 8'h00;
      px.green   = g;
      px.red     = fmt.swap ? b : r;
      px.blue    = fmt.swap ? r : b;
   end
endmodule

// File: rtl/fbu_linebytes.sv
module fbu_linebytes #(
   parameter int unsigned LINE_W = 12
) (
   input  logic [LINE_W-1:0] width,
   input  logic [2:0]        depth,
   output logic [LINE_W+1:0] bytes
);
   logic [LINE_W+1:0] w;
   assign w = {2'b00, width};

   always_comb begin
      case (depth)
         3'd0:    bytes = w >> 3;
         3'd1:    bytes = w >> 2;
         3'd2:    bytes = w >> 1;
         3'd3:    bytes = w;
         3'd5:    bytes = w << 2;
         default: bytes = w << 1;
      endcase
   end
endmodule

// File: rtl/fb_unpacker.sv
module fb_unpacker
   import fbu_pkg::*;
#(
   parameter  int unsigned EXTENDED = 1,
   parameter  int unsigned DATA_W   = 32,
   parameter  int unsigned LINE_W   = 12,
   localparam int unsigned CNT_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_depth,
   input  logic              cfg_bgr,
   input  logic              cfg_be_byte,
   input  logic              cfg_be_pix,
   input  logic [1:0]        fmt_mux,
   input  logic [LINE_W-1:0] line_width,
   output logic [LINE_W+1:0] line_bytes,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_indexed,
   output logic [7:0]        out_index,
   output logic [7:0]        out_red,
   output logic [7:0]        out_green,
   output logic [7:0]        out_blue
);
   if (DATA_W != 32) begin : g_bad_data_w
      $error("fb_unpacker: DATA_W must be 32");
   end
   if (EXTENDED > 1) begin : g_bad_variant
      $error("fb_unpacker: EXTENDED must be 0 or 1");
   end
   if (LINE_W < 4) begin : g_bad_line_w
      $error("fb_unpacker: LINE_W must be at least 4");
   end

   pix_fmt_t          fmt_d, fmt_q;
   order_e            ord_d, ord_q;
   logic [DATA_W-1:0] word_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              full_q;
   logic [CNT_W:0]    ppw;
   logic              last, load, take;
   logic [DATA_W-1:0] field;
   pix_out_t          px;

   fbu_format #(.EXTENDED(EXTENDED)) u_format (
      .depth (cfg_depth),
      .bgr   (cfg_bgr),
      .mux   (fmt_mux),
      .fmt   (fmt_d)
   );

   assign ord_d = cfg_be_byte ? ORD_BE_BYTE : (cfg_be_pix ? ORD_BE_PIX : ORD_LE);

   assign ppw      = (CNT_W+1)'(DATA_W) >> fmt_q.lsz;
   assign last     = ({1'b0, cnt_q} == (ppw - (CNT_W+1)'(1)));
   assign take     = full_q && out_ready;
   assign in_ready = !full_q || (out_ready && last);
   assign load     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         cnt_q  <= '0;
         word_q <= '0;
         fmt_q  <= FMT_RESET;
         ord_q  <= ORD_LE;
      end else if (load) begin
         full_q <= 1'b1;
         cnt_q  <= '0;
         word_q <= in_word;
         fmt_q  <= fmt_d;
         ord_q  <= ord_d;
      end else if (take) begin
         if (last) full_q <= 1'b0;
         else      cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   fbu_select #(.DATA_W(DATA_W)) u_select (
      .word  (word_q),
      .order (ord_q),
      .lsz   (fmt_q.lsz),
      .slot  (cnt_q),
      .field (field)
   );

   fbu_color #(.DATA_W(DATA_W)) u_color (
      .fmt   (fmt_q),
      .field (field),
      .px    (px)
   );

   fbu_linebytes #(.LINE_W(LINE_W)) u_linebytes (
      .width (line_width),
      .depth (cfg_depth),
      .bytes (line_bytes)
   );

   assign out_valid   = full_q;
   assign out_indexed = px.indexed;
   assign out_index   = px.index;
   assign out_red     = px.red;
   assign out_green   = px.green;
   assign out_blue    = px.blue;
endmodule

// File: rtl/fb_unpacker_chk.sv
module fb_unpacker_chk #(
   parameter int unsigned LINE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cfg_depth,
   input logic [LINE_W-1:0] line_width,
   input logic [LINE_W+1:0] line_bytes,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic              out_indexed,
   input logic [7:0]        out_index,
   input logic [7:0]        out_red,
   input logic [7:0]        out_green,
   input logic [7:0]        out_blue
);
   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready); // R1

   AST_FILL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid); // R2

   AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready); // R2

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid &&
         $stable({out_indexed, out_index, out_red, out_green, out_blue})); // R2

   AST_INDEX_NO_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_indexed |-> {out_red, out_green, out_blue} == 24'h0); // R3

   AST_BYTES_8BPP: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_depth == 3'd3 |-> line_bytes == {2'b00, line_width}); // R12
endmodule

bind fb_unpacker fb_unpacker_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/fb_unpacker_test.sv
`timescale 1ns/1ps
module fb_unpacker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_depth = 3'd0;
   logic        cfg_bgr = 1'b0, cfg_be_byte = 1'b0, cfg_be_pix = 1'b0;
   logic [1:0]  fmt_mux = 2'd0;
   logic [11:0] line_width = 12'd0;
   logic        in_valid = 1'b0, out_ready = 1'b0;
   logic [31:0] in_word = 32'h0;

   logic [13:0] lb_e, lb_b;
   logic        rdy_e, rdy_b, vld_e, vld_b, idx_e, idx_b;
   logic [7:0]  ix_e, ix_b, r_e, r_b, g_e, g_b, b_e, b_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   fb_unpacker #(.EXTENDED(1)) uut (
      .clk, .rst_n, .cfg_depth, .cfg_bgr, .cfg_be_byte, .cfg_be_pix, .fmt_mux,
      .line_width, .line_bytes(lb_e), .in_valid, .in_ready(rdy_e), .in_word,
      .out_valid(vld_e), .out_ready, .out_indexed(idx_e), .out_index(ix_e),
      .out_red(r_e), .out_green(g_e), .out_blue(b_e));

   fb_unpacker #(.EXTENDED(0)) uut_base (
      .clk, .rst_n, .cfg_depth, .cfg_bgr, .cfg_be_byte, .cfg_be_pix, .fmt_mux,
      .line_width, .line_bytes(lb_b), .in_valid, .in_ready(rdy_b), .in_word,
      .out_valid(vld_b), .out_ready, .out_indexed(idx_b), .out_index(ix_b),
      .out_red(r_b), .out_green(g_b), .out_blue(b_b));

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [32:0] model(input bit ext, input int depth, input bit bgr,
                                         input bit beb, input bit bep, input int mux,
                                         input logic [31:0] w, input int k);
      int d, lsz, psz, sh, kind, per;
      bit sw;
      logic [31:0] f;
      logic [7:0] r, g, b, t;
      d = depth;
      if (!ext && d >= 6) d = 4;
      sw = bgr;
      if (d <= 3) begin kind = 0; lsz = d; end
      else if (d == 5) begin kind = 4; lsz = 5; end
      else begin
         lsz = 4;
         if (ext) kind = (d == 4) ? 1 : (d == 6) ? 2 : 3;
         else begin
            kind = (mux == 1) ? 1 : 2;
            if (mux == 3) sw = 1;
         end
      end
      psz = 1 << lsz;
      if (beb) sh = 32 - (k + 1) * psz;
      else if (bep && psz < 8) begin
         per = 8 / psz;
         sh = (k / per) * 8 + 8 - ((k % per) + 1) * psz;
      end else sh = k * psz;
      f = w >> sh;
      if (psz < 32) f = f & ((32'd1 << psz) - 32'd1);
      r = 0; g = 0; b = 0;
      case (kind)
         1: begin r = 8'((f % 32) * 8); g = 8'(((f / 32) % 32) * 8); b = 8'(((f / 1024) % 32) * 8); end
         2: begin r = 8'((f % 32) * 8); g = 8'(((f / 32) % 64) * 4); b = 8'(((f / 2048) % 32) * 8); end
         3: begin r = 8'((f % 16) * 16); g = 8'(((f / 16) % 16) * 16); b = 8'(((f / 256) % 16) * 16); end
         4: begin r = 8'(f % 256); g = 8'((f / 256) % 256); b = 8'((f / 65536) % 256); end
         default: ;
      endcase
      if (kind == 0) return {1'b1, 8'(f), 24'h0};
      if (sw) begin t = r; r = b; b = t; end
      return {1'b0, 8'h00, r, g, b};
   endfunction

   function automatic string tag(input bit ext, input int depth, input bit bgr,
                                 input bit beb, input bit bep, input int mux);
      string s;
      if (beb && depth != 5) return "R5";
      if (depth <= 3) return (bep && depth <= 2) ? "R4" : "R3";
      if (!ext && depth != 5) return "R10";
      if (ext && (depth == 4 || depth == 6) && mux != 0) return "R11";
      if (depth == 4) s = "R6";
      else if (depth == 6) s = "R7";
      else s = "R8";
      if (bgr) s = "R9";
      return s;
   endfunction

   task automatic check_pix(input int depth, input int mux, input logic [31:0] w,
                            input int k);
      logic [32:0] ee, eb;
      ee = model(1, depth, cfg_bgr, cfg_be_byte, cfg_be_pix, mux, w, k);
      eb = model(0, depth, cfg_bgr, cfg_be_byte, cfg_be_pix, mux, w, k);
      check(vld_e && {idx_e, ix_e, r_e, g_e, b_e} == ee,
            tag(1, depth, cfg_bgr, cfg_be_byte, cfg_be_pix, mux),
            {vld_e, idx_e, ix_e, r_e, g_e, b_e}, {1'b1, ee});
      check(vld_b && {idx_b, ix_b, r_b, g_b, b_b} == eb,
            tag(0, depth, cfg_bgr, cfg_be_byte, cfg_be_pix, mux),
            {vld_b, idx_b, ix_b, r_b, g_b, b_b}, {1'b1, eb});
   endtask

   task automatic run_word(input int depth, input int ords, input bit bgr, input int mux,
                           input logic [31:0] w);
      int ppw;
      ppw = (depth <= 3) ? (32 >> depth) : (depth == 5) ? 1 : 2;
      @(negedge clk);
      cfg_depth = 3'(depth); cfg_be_byte = ords[1]; cfg_be_pix = ords[0];
      cfg_bgr = bgr; fmt_mux = 2'(mux); in_word = w; in_valid = 1'b1; out_ready = 1'b0;
      check(rdy_e && rdy_b && !vld_e, "R2", {rdy_e, rdy_b, vld_e}, 3'b110);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < ppw; k++) begin
         if (k == 0) begin
            in_valid = 1'b1; in_word = ~w;
            check(!rdy_e && !rdy_b, "R2", {rdy_e, rdy_b}, 2'b00);
            check_pix(depth, mux, w, 0);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check_pix(depth, mux, w, 0);
         end
         out_ready = 1'b1;
         check_pix(depth, mux, w, k);
         @(posedge clk);
         @(negedge clk);
      end
      out_ready = 1'b0;
      check(!vld_e && !vld_b, "R2", {vld_e, vld_b}, 2'b00);
   endtask

   function automatic logic [13:0] exp_bytes(input int depth, input int wd);
      case (depth)
         0: return 14'(wd / 8);
         1: return 14'(wd / 4);
         2: return 14'(wd / 2);
         3: return 14'(wd);
         5: return 14'(wd * 4);
         default: return 14'(wd * 2);
      endcase
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      int widths[6] = '{0, 1, 7, 8, 640, 4095};
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!vld_e && !vld_b && rdy_e && rdy_b, "R1", {vld_e, vld_b, rdy_e, rdy_b}, 4'b0011);
      rst_n = 1'b1;
      @(negedge clk);
      check(!vld_e && !vld_b && rdy_e && rdy_b, "R1", {vld_e, vld_b, rdy_e, rdy_b}, 4'b0011);

      for (int d = 0; d < 8; d++)
         for (int o = 0; o < 4; o++)
            for (int bg = 0; bg < 2; bg++)
               for (int m = 0; m < 4; m++) begin
                  run_word(d, o, bit'(bg), m, 32'hA5C3_1E69);
                  run_word(d, o, bit'(bg), m, 32'h7B2D_F094);
               end

      for (int d = 0; d < 8; d++)
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cfg_depth = 3'(d); line_width = 12'(widths[i]);
            #1;
            check(lb_e == exp_bytes(d, widths[i]) && lb_b == exp_bytes(d, widths[i]),
                  "R12", {lb_e, lb_b}, {exp_bytes(d, widths[i]), exp_bytes(d, widths[i])});
         end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule